// File: doc/BRIEF.md
# Dual-Mode Saturating Multiply-Accumulate Unit

This unit multiplies a pair of signed operands and adds the product into a 64-bit accumulator, kept as a high word and a low word. A long operation multiplies two signed 32-bit operands. A word operation multiplies the signed low halves (16 bits) of the two operands. A saturation-mode bit, sampled together with the start strobe, selects plain wrap-around accumulation or saturating accumulation. The two operations saturate in different ways.

A long operation in saturating mode limits the whole accumulator to a 48-bit signed range, held sign-extended. A word operation in saturating mode works on the low word alone: the high word takes no part in the sum. On a 32-bit overflow the low word is pinned to a 32-bit limit and the high word is set to 1. Software-visible state is limited to the two accumulator words. They can be cleared, or loaded one word at a time, through dedicated ports.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset both accumulator words read 0 and `done` is low.
- R2: A long operation (`op_word`=0) with `sat_en`=0 adds the full 64-bit signed product of `opa` and `opb` to {`acc_hi`,`acc_lo`}, wrapping modulo 2^64.
- R3: A long operation with `sat_en`=1 clamps the exact sum into the range -(2^47) to 2^47-1, stored sign-extended in the 64-bit accumulator.
- R4: A long operation with `sat_en`=1 whose 64-bit addition overflows gives 2^47-1 when the old accumulator was non-negative and -(2^47) when it was negative.
- R5: A word operation (`op_word`=1) uses only bits 15:0 of `opa` and `opb` as signed 16-bit values; bits 31:16 have no effect. With `sat_en`=0 the 32-bit product, sign-extended, is added to the full 64-bit accumulator.
- R6: A word operation with `sat_en`=1 adds the product to `acc_lo` only. No carry reaches `acc_hi`. A 32-bit signed overflow pins `acc_lo` to 0x7FFFFFFF when the old low word was non-negative and to 0x80000000 when it was negative.
- R7: A word operation with `sat_en`=1 sets `acc_hi` to 1 on a 32-bit overflow and leaves `acc_hi` unchanged otherwise.
- R8: An accepted start updates the accumulator at the next clock edge. `done` is high for exactly the cycle after each accepted start and is low at all other times.
- R9: `clr` zeroes both words at the next edge. It takes priority over the loads and over `start`, and a start in that cycle is not accepted.
- R10: `ld_hi` writes `ld_data` into `acc_hi` and `ld_lo` writes `ld_data` into `acc_lo`; both may be asserted together. A start in a load cycle is not accepted.
- R11: With no start, clear or load asserted, both accumulator words hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one multiply-accumulate |
| op_word | input | 1 | 1 = 16x16 word operation, 0 = 32x32 long operation |
| sat_en | input | 1 | Saturating accumulation when 1 |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| clr | input | 1 | Zero both accumulator words |
| ld_hi | input | 1 | Load high word from ld_data |
| ld_lo | input | 1 | Load low word from ld_data |
| ld_data | input | 32 | Load value |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |
| done | output | 1 | One-cycle strobe after an accepted start |

## Verification
The hardest states to reach are the saturation boundaries. Random products alone would need thousands of operations to move the accumulator to ±2^47, to the 64-bit overflow edge, or to a low word one step from the 32-bit limit. The bench therefore uses the load ports to place the accumulator directly beside each limit and then fires small products across it. It also covers the case where the 64-bit sum itself wraps. Random runs then interleave random loads, including values near the limits, with random operations, saturation modes and operand high halves.

// File: rtl/sat_mac_unit.sv
module sat_mac_unit #(
  parameter int SAT_BITS = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_word,
  input  logic        sat_en,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic        clr,
  input  logic        ld_hi,
  input  logic        ld_lo,
  input  logic [31:0] ld_data,
  output logic [31:0] acc_hi,
  output logic [31:0] acc_lo,
  output logic        done
);
  localparam logic [63:0] POS_LIM = (64'd1 << (SAT_BITS - 1)) - 64'd1;
  localparam logic [63:0] NEG_LIM = ~POS_LIM;
  localparam logic [31:0] W_MAX   = 32'h7FFF_FFFF;
  localparam logic [31:0] W_MIN   = 32'h8000_0000;

  logic        go;
  logic [63:0] acc, prod_l, prod_w64, addend, sum_l, clamp_l;
  logic [31:0] prod_w, sum_w;
  logic        ovf_l, ovf_w;
  logic [31:0] nxt_hi, nxt_lo;

  assign go  = start & ~clr & ~ld_hi & ~ld_lo;
  assign acc = {acc_hi, acc_lo};

  assign prod_l   = {{32{opa[31]}}, opa} * {{32{opb[31]}}, opb};
  assign prod_w   = {{16{opa[15]}}, opa[15:0]} * {{16{opb[15]}}, opb[15:0]};
  assign prod_w64 = {{32{prod_w[31]}}, prod_w};
  assign addend   = op_word ? prod_w64 : prod_l;
  assign sum_l    = acc + addend;
  assign ovf_l    = (acc[63] == addend[63]) && (sum_l[63] != acc[63]);
  assign sum_w    = acc_lo + prod_w;
  assign ovf_w    = (acc_lo[31] == prod_w[31]) && (sum_w[31] != acc_lo[31]);

  always_comb begin
    if (ovf_l)
      clamp_l = acc[63] ? NEG_LIM : POS_LIM;
    else if ($signed(sum_l) > $signed(POS_LIM))
      clamp_l = POS_LIM;
    else if ($signed(sum_l) < $signed(NEG_LIM))
      clamp_l = NEG_LIM;
    else
      clamp_l = sum_l;
  end

  always_comb begin
    {nxt_hi, nxt_lo} = sum_l;
    if (sat_en) begin
      if (op_word) begin
        nxt_hi = ovf_w ? 32'd1 : acc_hi;
        nxt_lo = ovf_w ? (acc_lo[31] ? W_MIN : W_MAX) : sum_w;
      end else begin
        {nxt_hi, nxt_lo} = clamp_l;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
      done   <= 1'b0;
    end else begin
      done <= go;
      if (clr) begin
        acc_hi <= '0;
        acc_lo <= '0;
      end else if (ld_hi || ld_lo) begin
        if (ld_hi) acc_hi <= ld_data;
        if (ld_lo) acc_lo <= ld_data;
      end else if (go) begin
        acc_hi <= nxt_hi;
        acc_lo <= nxt_lo;
      end
    end
  end

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr && !ld_hi && !ld_lo) |=> done);
  a_r8_done_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !clr && !ld_hi && !ld_lo) |=> !done);
  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_hi == 32'd0 && acc_lo == 32'd0));
  a_r3_long_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !op_word && sat_en) |=>
      ($signed(acc) <= $signed(POS_LIM) && $signed(acc) >= $signed(NEG_LIM)));
  a_r7_word_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_word && sat_en) |=> (acc_hi == $past(acc_hi) || acc_hi == 32'd1));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !clr && !ld_hi && !ld_lo) |=> ($stable(acc_hi) && $stable(acc_lo)));
  a_r10_load_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !clr) |=> acc_hi == $past(ld_data));
endmodule

// File: tb/sat_mac_unit_test.sv
`timescale 1ns/1ps
module sat_mac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_word = 1'b0, sat_en = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] model = '0;

  always #2.5 clk = ~clk;

  sat_mac_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word), .sat_en(sat_en),
    .opa(opa), .opb(opb), .clr(clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_data(ld_data), .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  function automatic logic [63:0] ref_step(logic [63:0] acc, logic [31:0] a,
                                           logic [31:0] b, logic w, logic s);
    longint pa, pb, p;
    logic signed [65:0] ex;
    logic signed [33:0] ew;
    logic [31:0] hi;
    pa = w ? longint'($signed(a[15:0])) : longint'($signed(a));
    pb = w ? longint'($signed(b[15:0])) : longint'($signed(b));
    p  = pa * pb;
    if (!s) return acc + 64'(p);
    if (!w) begin
      ex = $signed({{2{acc[63]}}, acc}) + 66'(p);
      if (ex > 66'sh0_7FFF_FFFF_FFFF) return 64'h0000_7FFF_FFFF_FFFF;
      if (ex < -66'sh0_8000_0000_0000) return 64'hFFFF_8000_0000_0000;
      return ex[63:0];
    end
    ew = $signed({{2{acc[31]}}, acc[31:0]}) + 34'(p);
    hi = acc[63:32];
    if (ew > 34'sh0_7FFF_FFFF) return {32'd1, 32'h7FFF_FFFF};
    if (ew < -34'sh0_8000_0000) return {32'd1, 32'h8000_0000};
    return {hi, ew[31:0]};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_op(string req, logic [31:0] a, logic [31:0] b, logic w, logic s);
    start = 1'b1; opa = a; opb = b; op_word = w; sat_en = s;
    model = ref_step(model, a, b, w, s);
    @(negedge clk);
    start = 1'b0; opa = $urandom; opb = $urandom; sat_en = $urandom;
    check(req, {acc_hi, acc_lo}, model);
    check("R8 done", {63'd0, done}, 64'd1);
  endtask

  task automatic do_load(logic h, logic l, logic [31:0] d, logic st);
    ld_hi = h; ld_lo = l; ld_data = d; start = st; opa = 32'd7; opb = 32'd9;
    if (h) model[63:32] = d;
    if (l) model[31:0] = d;
    @(negedge clk);
    ld_hi = 1'b0; ld_lo = 1'b0; start = 1'b0;
  endtask

  task automatic set_acc(logic [63:0] v);
    do_load(1'b1, 1'b1, v[31:0], 1'b0);
    do_load(1'b1, 1'b0, v[63:32], 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    check("R1 reset done", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_op("R2 long wrap", 32'hFFFF_FFFF, 32'd5, 1'b0, 1'b0);
    set_acc(64'h7FFF_FFFF_FFFF_FFFF);
    do_op("R2 long wrap 2^64", 32'd2, 32'd3, 1'b0, 1'b0);
    set_acc(64'h0000_7FFF_FFFF_FFF0);
    do_op("R3 long clamp pos", 32'd100, 32'd1, 1'b0, 1'b1);
    check("R3 pos limit", {acc_hi, acc_lo}, 64'h0000_7FFF_FFFF_FFFF);
    set_acc(64'hFFFF_8000_0000_0010);
    do_op("R3 long clamp neg", 32'hFFFF_FF00, 32'd1, 1'b0, 1'b1);
    check("R3 neg limit", {acc_hi, acc_lo}, 64'hFFFF_8000_0000_0000);
    set_acc(64'h7FFF_FFFF_FFFF_FF00);
    do_op("R4 64-bit ovf pos", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1);
    check("R4 pos", {acc_hi, acc_lo}, 64'h0000_7FFF_FFFF_FFFF);
    set_acc(64'h8000_0000_0000_0100);
    do_op("R4 64-bit ovf neg", 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1);
    check("R4 neg", {acc_hi, acc_lo}, 64'hFFFF_8000_0000_0000);
    set_acc(64'h0000_0005_FFFF_FFFF);
    do_op("R5 word carry into hi", 32'hABCD_0001, 32'h1234_0001, 1'b1, 1'b0);
    check("R5 carry", {acc_hi, acc_lo}, 64'h0000_0006_0000_0000);
    set_acc(64'd0);
    do_op("R5 word sign", 32'hFFFF_8000, 32'h0000_7FFF, 1'b1, 1'b0);
    set_acc(64'h0000_1234_7FFF_FFF0);
    do_op("R6 word sat pos", 32'd64, 32'd1, 1'b1, 1'b1);
    check("R7 hi set", {acc_hi, acc_lo}, 64'h0000_0001_7FFF_FFFF);
    set_acc(64'h0000_4321_8000_0002);
    do_op("R6 word sat neg", 32'hFFFF_FFF0, 32'd1, 1'b1, 1'b1);
    check("R7 hi set neg", {acc_hi, acc_lo}, 64'h0000_0001_8000_0000);
    set_acc(64'h0000_00AA_FFFF_FFFF);
    do_op("R6 no carry to hi", 32'd1, 32'd1, 1'b1, 1'b1);
    check("R7 hi kept", {acc_hi, acc_lo}, 64'h0000_00AA_0000_0000);

    start = 1'b1; clr = 1'b1; ld_hi = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0; ld_hi = 1'b0; model = '0;
    check("R9 clear", {acc_hi, acc_lo}, 64'd0);
    check("R9 start dropped", {63'd0, done}, 64'd0);
    do_load(1'b0, 1'b1, 32'hCAFE_0001, 1'b1);
    check("R10 load lo", {acc_hi, acc_lo}, model);
    check("R10 start dropped", {63'd0, done}, 64'd0);
    repeat (4) @(negedge clk);
    check("R11 hold", {acc_hi, acc_lo}, model);
    check("R8 idle done", {63'd0, done}, 64'd0);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 15);
      if (r == 0) set_acc({$urandom, $urandom});
      else if (r == 1) set_acc({16'h0000, 16'h7FFF, $urandom});
      else if (r == 2) set_acc({32'h0000_0003, 16'h7FFF, 16'($urandom)});
      else if (r == 3) set_acc({16'hFFFF, 16'h8000, $urandom});
      else if (r < 6) do_op("R3 random long", $urandom, $urandom, 1'b0, 1'($urandom));
      else do_op("R6 random word", $urandom, $urandom, 1'($urandom), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule